// File: doc/BRIEF.md
# Byte-Wide Memory with BCD Calendar Clock

A synchronous byte-wide storage array whose eight highest addresses form a calendar clock window. Hidden counters keep seconds, minutes, hours (24-hour), day of the week, date, month and two-digit year, all in packed BCD. A divider counts strobes from a 32,768 Hz timebase and advances the counters once per second.

The seven time bytes the host sees are ordinary read/write cells. One cycle after each counter advance they are refreshed from the counters. The lowest byte of the window is a control register. Two of its bits gate that refresh, and bit 7 also loads a new time into the counters. Its lower six bits hold a calibration value that is only stored. A power-fail input blocks every host write. The array depth is set by `ADDR_W`: the default of 11 gives 2 KiB, and 13 gives the full 8 KiB map with the clock window at 1FF8h–1FFFh.

Top module: `bcd_rtc_mem`

## Requirements
- R1: After reset the clock window reads sec=00, min=00, hour=00, day-of-week=01, date=01, month=01, year=00 and control=00, and `data_oe_o` is low. Window offsets from base (2^ADDR_W−8) are: +0 control, +1 sec, +2 min, +3 hour, +4 day-of-week, +5 date, +6 month, +7 year.
- R2: A read (we_ni=1, ce1_ni=0, ce2_i=1, oe_ni=0) presents the addressed byte on `data_o` with `data_oe_o`=1 one cycle later. A write (we_ni=0, ce1_ni=0, ce2_i=1) stores `data_i` at the clock edge. With any other input pattern nothing is stored and `data_oe_o` is 0 in the following cycle.
- R3: While `pwr_fail_i` is 1, no write changes the array, the time bytes or the control register.
- R4: Every `TICKS_PER_SEC` cycles that have `tick_i`=1, the counters advance by one second.
- R5: One cycle after each advance, the time bytes take the counter values, unless control bit 7 or bit 6 is set. Between refreshes, a host write to a time byte reads back as written.
- R6: While control bit 6 is set, the time bytes stay frozen and the counters keep running. Clearing bit 6 does not load the counters.
- R7: A control write that clears bit 7 while bit 7 was set loads the counters from the seven time bytes and restarts the one-second divider.
- R8: Seconds wrap 59→00 and carry to minutes. Minutes wrap 59→00 and carry to hours. Hours wrap 23→00.
- R9: The hour wrap steps day-of-week (07→01) and the date together.
- R10: The date past 30 in months 04, 06, 09 and 11, or past 31 in the other months except 02, becomes 01 and carries to the month.
- R11: February ends at 29 when the BCD year is divisible by four (00 included), otherwise at 28.
- R12: Month 12 wraps to 01 and carries to the year. Year 99 wraps to 00.
- R13: Control bits 5:0 read back as written and have no effect on timekeeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at the 32,768 Hz timebase rate |
| pwr_fail_i | input | 1 | Supply-fail flag; blocks all writes |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| data_o | output | 8 | Read data, registered; zero when not reading |
| data_oe_o | output | 1 | High in the cycle `data_o` carries read data |

## Verification
The properties assume the host loads only legal BCD values into the time bytes, so day-of-week stays in 1–7 and the date stays within the month. They also assume `tick_i` and every host input are single-cycle synchronous levels. The bench loads each calendar vector through the bit-7 sequence with valid BCD only. It raises and drops `tick_i` on the falling clock edge and never ticks while an access is in progress. This keeps every expected second boundary at a cycle the bench can count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int N_TIME = 7;

  typedef logic [N_TIME-1:0][BYTE_W-1:0] rtc_bytes_t;

  localparam int SEC = 0;
  localparam int MIN = 1;
  localparam int HR  = 2;
  localparam int DOW = 3;
  localparam int DAT = 4;
  localparam int MON = 5;
  localparam int YR  = 6;

  // {yr, mon, date, dow, hr, min, sec}
  localparam rtc_bytes_t RTC_RESET = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // returns {carry, next}
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] base);
    if (v >= top)         return {1'b1, base};
    if (v[3:0] >= 4'd9)   return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 = 2 mod 4, so (2*tens + ones) mod 4 decides
  function automatic logic is_leap(input logic [7:0] yr);
    logic [5:0] s;
    s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic pulse_o
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign pulse_o = tick_i && at_last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       load_i,
  input  rtc_bytes_t load_val_i,
  output rtc_bytes_t now_o
);
  rtc_bytes_t now_q, nxt;
  logic [8:0] c_sec, c_min, c_hr, c_dow, c_dat, c_mon, c_yr;
  logic       roll_min, roll_hr, roll_day, roll_mon, roll_yr;
  logic       unused_carry;

  always_comb begin
    c_sec = bcd_step(now_q[SEC], 8'h59, 8'h00);
    c_min = bcd_step(now_q[MIN], 8'h59, 8'h00);
    c_hr  = bcd_step(now_q[HR],  8'h23, 8'h00);
    c_dow = bcd_step(now_q[DOW], 8'h07, 8'h01);
    c_dat = bcd_step(now_q[DAT], month_end(now_q[MON], is_leap(now_q[YR])), 8'h01);
    c_mon = bcd_step(now_q[MON], 8'h12, 8'h01);
    c_yr  = bcd_step(now_q[YR],  8'h99, 8'h00);

    roll_min = c_sec[8];
    roll_hr  = roll_min && c_min[8];
    roll_day = roll_hr && c_hr[8];
    roll_mon = roll_day && c_dat[8];
    roll_yr  = roll_mon && c_mon[8];

    nxt      = now_q;
    nxt[SEC] = c_sec[7:0];
    if (roll_min) nxt[MIN] = c_min[7:0];
    if (roll_hr)  nxt[HR]  = c_hr[7:0];
    if (roll_day) begin
      nxt[DOW] = c_dow[7:0];
      nxt[DAT] = c_dat[7:0];
    end
    if (roll_mon) nxt[MON] = c_mon[7:0];
    if (roll_yr)  nxt[YR]  = c_yr[7:0];
  end

  assign unused_carry = c_dow[8] | c_yr[8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     now_q <= RTC_RESET;
    else if (load_i) now_q <= load_val_i;
    else if (step_i) now_q <= nxt;
  end

  assign now_o = now_q;
endmodule

// File: rtl/rtc_sram.sv
module rtc_sram #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 2040,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/bcd_rtc_mem.sv
module bcd_rtc_mem
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwr_fail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              oe_ni,
  input  logic              we_ni,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int RAM_DEPTH = (1 << ADDR_W) - 8;

  logic             sel, rd_en, wr_en, in_clk, wr_ctrl, wr_time, load;
  logic [2:0]       slot, slot_m1;
  logic [BYTE_W-1:0] ctrl_q, ram_rdata, win_byte, data_q;
  logic             data_oe_q, upd_q, sec_pulse;
  rtc_bytes_t       tm_q, cal_now;

  assign sel     = !ce1_ni && ce2_i;
  assign rd_en   = sel && we_ni && !oe_ni;
  assign wr_en   = sel && !we_ni && !pwr_fail_i;
  assign in_clk  = &addr_i[ADDR_W-1:3];
  assign slot    = addr_i[2:0];
  assign slot_m1 = slot - 3'd1;
  assign wr_ctrl = wr_en && in_clk && (slot == 3'd0);
  assign wr_time = wr_en && in_clk && (slot != 3'd0);
  // bit 7 falling under host control commits the edited time
  assign load    = wr_ctrl && ctrl_q[7] && !data_i[7];

  rtc_sram #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH), .DATA_W(BYTE_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en && !in_clk),
    .addr_i (addr_i),
    .wdata_i(data_i),
    .rdata_o(ram_rdata)
  );

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (load),
    .pulse_o(sec_pulse)
  );

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (sec_pulse),
    .load_i    (load),
    .load_val_i(tm_q),
    .now_o     (cal_now)
  );

  assign win_byte = (slot == 3'd0) ? ctrl_q : tm_q[slot_m1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tm_q      <= RTC_RESET;
      upd_q     <= 1'b0;
      data_q    <= '0;
      data_oe_q <= 1'b0;
    end else begin
      upd_q     <= sec_pulse;
      data_oe_q <= rd_en;
      data_q    <= rd_en ? (in_clk ? win_byte : ram_rdata) : '0;
      if (upd_q && !ctrl_q[7] && !ctrl_q[6]) tm_q <= cal_now;
      if (wr_time) tm_q[slot_m1] <= data_i;  // host write wins over refresh
      if (wr_ctrl) ctrl_q <= data_i;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = data_oe_q;
endmodule

// File: rtl/rtc_mem_checker.sv
module rtc_mem_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_fail_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] data_i,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              data_oe_o,
  input logic [BYTE_W-1:0] ctrl_q,
  input rtc_bytes_t        tm_q,
  input rtc_bytes_t        cal_now,
  input logic              sec_pulse
);
  logic rd, wr_any, win, wr_win, loading;

  assign rd      = !ce1_ni && ce2_i && we_ni && !oe_ni;
  assign wr_any  = !ce1_ni && ce2_i && !we_ni && !pwr_fail_i;
  assign win     = &addr_i[ADDR_W-1:3];
  assign wr_win  = wr_any && win && (addr_i[2:0] != 3'd0);
  assign loading = wr_any && win && (addr_i[2:0] == 3'd0) && ctrl_q[7] && !data_i[7];

  p_read_drives_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> data_oe_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !data_oe_o);

  p_pf_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> $stable(ctrl_q));

  p_sec_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !loading) |=> !$stable(cal_now[SEC]));

  p_wbit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[7] && !wr_win) |=> $stable(tm_q));

  p_rbit_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[6] && !wr_win) |=> $stable(tm_q));

  p_hour_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !loading && cal_now[HR] == 8'h23 && cal_now[MIN] == 8'h59 &&
     cal_now[SEC] == 8'h59) |=> (cal_now[HR] == 8'h00));

  p_dow_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !loading && cal_now[HR] == 8'h23 && cal_now[MIN] == 8'h59 &&
     cal_now[SEC] == 8'h59 && cal_now[DOW] == 8'h07) |=> (cal_now[DOW] == 8'h01));
endmodule

bind bcd_rtc_mem rtc_mem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_fail_i(pwr_fail_i),
  .addr_i    (addr_i),
  .data_i    (data_i),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .oe_ni     (oe_ni),
  .we_ni     (we_ni),
  .data_oe_o (data_oe_o),
  .ctrl_q    (ctrl_q),
  .tm_q      (tm_q),
  .cal_now   (cal_now),
  .sec_pulse (sec_pulse)
);

// File: tb/bcd_rtc_mem_tb_top.sv
module bcd_rtc_mem_tb_top;
  localparam int ADDR_W = 11;
  localparam int TPS    = 4;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'((1 << ADDR_W) - 8);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              pf = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic              ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]        rdata;
  logic              rd_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bcd_rtc_mem #(.ADDR_W(ADDR_W), .TICKS_PER_SEC(TPS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwr_fail_i(pf),
    .addr_i(addr), .data_i(wdata), .ce1_ni(ce1_n), .ce2_i(ce2),
    .oe_ni(oe_n), .we_ni(we_n), .data_o(rdata), .data_oe_o(rd_oe)
  );

  // {start, expected} as {yr,mon,date,dow,hr,min,sec}
  localparam logic [111:0] VEC [13] = '{
    {56'h00010101000000, 56'h00010101000001},  // R4
    {56'h24061503123409, 56'h24061503123410},  // R4 BCD digit carry
    {56'h24061503123459, 56'h24061503123500},  // R8
    {56'h24061503125959, 56'h24061503130000},  // R8
    {56'h24031507235959, 56'h24031601000000},  // R8 R9
    {56'h24043002235959, 56'h24050103000000},  // R10
    {56'h24013103235959, 56'h24020104000000},  // R10
    {56'h23022802235959, 56'h23030103000000},  // R11
    {56'h24022803235959, 56'h24022904000000},  // R11
    {56'h24022904235959, 56'h24030105000000},  // R11
    {56'h99123105235959, 56'h00010106000000},  // R12
    {56'h00022801235959, 56'h00022902000000},  // R11
    {56'h24113006235959, 56'h24120107000000}   // R10
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic bus(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic c1n,
                     input logic c2, input logic wn, input logic on);
    @(negedge clk);
    addr = a; wdata = d; ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus(a, d, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic v);
    bus(a, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    d = rdata; v = rd_oe;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);  // refresh of the visible bytes
  endtask

  task automatic set_time(input logic [55:0] t);
    wr(BASE, 8'h80);
    for (int i = 0; i < 7; i++) wr(BASE + ADDR_W'(i + 1), t[i*8 +: 8]);
    wr(BASE, 8'h00);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    logic v;
    for (int i = 0; i < 7; i++) begin
      rd(BASE + ADDR_W'(i + 1), b, v);
      t[i*8 +: 8] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    logic        v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_oe == 1'b0, "R1 idle output enable", 64'(rd_oe), 64'd0);
    read_time(t);
    chk(t == 56'h00010101000000, "R1 reset time", 64'(t), 64'h00010101000000);
    rd(BASE, b, v);
    chk(b == 8'h00 && v, "R1 reset control", 64'(b), 64'h00);

    // R2 plain storage and decode
    wr(ADDR_W'(5), 8'hA5);
    rd(ADDR_W'(5), b, v);
    chk(b == 8'hA5 && v, "R2 ram readback", 64'(b), 64'hA5);
    wr(BASE - 1, 8'h5A);
    rd(BASE - 1, b, v);
    chk(b == 8'h5A, "R2 top plain byte", 64'(b), 64'h5A);
    bus(ADDR_W'(5), 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(rd_oe == 1'b0, "R2 oe high no drive", 64'(rd_oe), 64'd0);
    bus(ADDR_W'(5), 8'h11, 1'b0, 1'b0, 1'b0, 1'b1);  // ce2 low
    bus(ADDR_W'(5), 8'h22, 1'b1, 1'b1, 1'b0, 1'b1);  // ce1 high
    rd(ADDR_W'(5), b, v);
    chk(b == 8'hA5, "R2 deselected write ignored", 64'(b), 64'hA5);

    // R3 power fail
    pf = 1'b1;
    wr(ADDR_W'(5), 8'h3C);
    wr(BASE, 8'h2A);
    wr(BASE + 1, 8'h45);
    pf = 1'b0;
    rd(ADDR_W'(5), b, v);
    chk(b == 8'hA5, "R3 ram write blocked", 64'(b), 64'hA5);
    rd(BASE, b, v);
    chk(b == 8'h00, "R3 control write blocked", 64'(b), 64'h00);
    rd(BASE + 1, b, v);
    chk(b == 8'h00, "R3 time write blocked", 64'(b), 64'h00);

    // R13 calibration field
    wr(BASE, 8'h2A);
    rd(BASE, b, v);
    chk(b == 8'h2A, "R13 calibration readback", 64'(b), 64'h2A);

    // R7 divider restart on load, R4 tick count
    wr(BASE, 8'hAA);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    for (int i = 0; i < 7; i++) wr(BASE + ADDR_W'(i + 1), 8'h00);
    wr(BASE, 8'h2A);
    ticks(TPS - 1);
    rd(BASE + 1, b, v);
    chk(b == 8'h00, "R7 divider restarted", 64'(b), 64'h00);
    ticks(1);
    rd(BASE + 1, b, v);
    chk(b == 8'h01, "R4 one second per TPS ticks", 64'(b), 64'h01);
    rd(BASE, b, v);
    chk(b == 8'h2A, "R13 field kept while counting", 64'(b), 64'h2A);
    wr(BASE, 8'h00);

    // R5 ordinary cell overwritten at next refresh
    wr(BASE + 2, 8'h45);
    rd(BASE + 2, b, v);
    chk(b == 8'h45, "R5 time byte readback", 64'(b), 64'h45);
    ticks(TPS);
    rd(BASE + 2, b, v);
    chk(b == 8'h00, "R5 refresh from counters", 64'(b), 64'h00);

    // R5 bit 7 blocks refresh, R7 load
    wr(BASE, 8'h80);
    ticks(TPS);
    rd(BASE + 1, b, v);
    chk(b == 8'h02, "R5 write bit holds bytes", 64'(b), 64'h02);
    wr(BASE + 1, 8'h30);
    wr(BASE, 8'h00);
    ticks(TPS);
    rd(BASE + 1, b, v);
    chk(b == 8'h31, "R7 load from bytes", 64'(b), 64'h31);

    // R6 read bit freezes, counters run
    wr(BASE, 8'h40);
    ticks(TPS);
    ticks(TPS);
    rd(BASE + 1, b, v);
    chk(b == 8'h31, "R6 frozen snapshot", 64'(b), 64'h31);
    wr(BASE, 8'h00);
    ticks(TPS);
    rd(BASE + 1, b, v);
    chk(b == 8'h34, "R6 counters kept running", 64'(b), 64'h34);

    // calendar vectors: R4 R8 R9 R10 R11 R12
    for (int i = 0; i < 13; i++) begin
      set_time(VEC[i][111:56]);
      ticks(TPS);
      read_time(t);
      chk(t == VEC[i][55:0], $sformatf("R8/R9/R10/R11/R12 vector %0d", i),
          64'(t), 64'(VEC[i][55:0]));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule